// File: doc/BRIEF.md
# Levelled Interrupt Controller with Fast Bypass

This controller gathers 27 levelled request lines (8 external, active-low, and 19 internal, active-high) plus one dedicated fast-interrupt pin, 28 sources in total. Every levelled source carries a 3-bit priority. A rising request edge latches a pending bit. The controller compares pending work against the level currently being serviced and raises a normal interrupt to the processor only when a pending source outranks that level. The fast-interrupt pin bypasses all of this and drives the fast interrupt output directly.

Software reads a vector register to learn the winning source's unique number. That read also acknowledges the source: its pending bit clears, the current level is saved on a small level stack, and the winner's level becomes the new current level. A write to the end-of-service register restores the saved level. Nesting follows from this: only strictly higher levels can interrupt a handler.

Register map on the 3-bit bus address: 0..3 hold level words, 4 holds pending status, 5 is the vector, 6 is end-of-service (write only), and 7 is the current level (read only). Read data is combinational while the read strobe is high.

Top module: `prio_intc`

## Requirements
- R1: After reset, irq_o and fiq_o are 0, every level is 0, the pending register reads 0, the current level reads 0 and the vector reads 0.
- R2: An external line held low for at least two clock cycles sets pending bit i, where i is the line index 0..7. The fall is detected after a two-stage synchroniser.
- R3: A pending source whose level is 0 never raises irq_o and is never returned by a vector read.
- R4: irq_o is 1 exactly when some pending source has a level strictly greater than the current level.
- R5: A vector read returns the winning source number plus one, where the winner is the pending source with the highest level. It returns 0 when irq_o is 0.
- R6: Among pending sources that share the highest level, the one with the lowest source number wins.
- R7: A vector read that returns a nonzero value clears the winner's pending bit, pushes the current level onto the level stack, and sets the current level (address 7, bits 2:0) to the winner's level. A read of 0 changes nothing.
- R8: A write to address 6 pops the level stack into the current level. With an empty stack, the current level becomes 0.
- R9: fiq_o follows the inverted fast pin fiq_ni after two clock stages, regardless of levels or the current level.
- R10: A rising edge on internal line k sets pending bit 8+k.
- R11: Level word w (address 0..3) holds the level of source 8w+j in bits 4j+2..4j. Writes update those fields and reads return them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_irq_ni | input | 8 | External requests, active low, asynchronous |
| fiq_ni | input | 1 | Dedicated fast-interrupt pin, active low |
| int_irq_i | input | 19 | Internal requests, active high, synchronous |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid while bus_rd_i is high |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The arbitration is driven with a mix of sources: disabled, low and mid levels, a tie between two sources at one level, and a single top-level source. These separate the choice by highest level from the lowest-number tie break. They also show that a disabled source latches but never competes. Nested acknowledge and end-of-service sequences walk the current level up and down, with requests at, below and above the serviced level. These distinguish strict from non-strict masking and show that the stack restores the earlier levels in order. A two-cycle external pulse and a fast-pin pulse taken during servicing cover the synchronised paths.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
    localparam int NUM_EXT      = 8;
    localparam int NUM_INTL     = 19;
    localparam int LVL_W        = 3;
    localparam int NSRC         = NUM_EXT + NUM_INTL;
    localparam int SRC_W        = $clog2(NSRC + 1);
    localparam int LVL_PER_WORD = 8;
    localparam int NUM_LVL_WORDS = (NSRC + LVL_PER_WORD - 1) / LVL_PER_WORD;
    localparam int STK_DEPTH    = (1 << LVL_W) - 1;
    localparam int ADDR_W       = 3;
    localparam int DATA_W       = 32;

    localparam logic [ADDR_W-1:0] A_PEND = 3'd4;
    localparam logic [ADDR_W-1:0] A_VEC  = 3'd5;
    localparam logic [ADDR_W-1:0] A_EOS  = 3'd6;
    localparam logic [ADDR_W-1:0] A_CUR  = 3'd7;

    typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/prio_intc_edge.sv
module prio_intc_edge #(
    parameter int SYNC_STAGES = 2,
    parameter bit ACT_LOW     = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_i,
    output logic pulse_o
);
    logic act;
    logic level;
    logic prev_d, prev_q;

    assign act = ACT_LOW ? ~req_i : req_i;

    generate
        if (SYNC_STAGES > 0) begin : g_sync
            logic [SYNC_STAGES-1:0] sync_d, sync_q;
            always_comb begin
                sync_d[0] = act;
                for (int k = 1; k < SYNC_STAGES; k++) sync_d[k] = sync_q[k-1];
            end
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) sync_q <= '0;
                else         sync_q <= sync_d;
            end
            assign level = sync_q[SYNC_STAGES-1];
        end else begin : g_direct
            assign level = act;
        end
    endgenerate

    always_comb prev_d = level;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= prev_d;
    end

    assign pulse_o = level & ~prev_q;
endmodule

// File: rtl/prio_intc_arb.sv
module prio_intc_arb
    import prio_intc_pkg::*;
(
    input  logic [NSRC-1:0]            pend_i,
    input  logic [NSRC-1:0][LVL_W-1:0] lvl_i,
    input  lvl_t                       cur_i,
    output logic                       win_valid_o,
    output logic [SRC_W-1:0]           win_idx_o,
    output lvl_t                       win_lvl_o
);
    lvl_t             best_lvl;
    logic [SRC_W-1:0] best_idx;

    always_comb begin
        best_lvl = '0;
        best_idx = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (pend_i[i] && (lvl_i[i] > best_lvl)) begin
                best_lvl = lvl_i[i];
                best_idx = SRC_W'(i);
            end
        end
    end

    assign win_valid_o = best_lvl > cur_i;
    assign win_idx_o   = best_idx;
    assign win_lvl_o   = best_lvl;
endmodule

// File: rtl/prio_intc_stack.sv
module prio_intc_stack
    import prio_intc_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic push_i,
    input  lvl_t push_lvl_i,
    input  logic pop_i,
    output lvl_t top_o,
    output logic [$clog2(STK_DEPTH+1)-1:0] depth_o
);
    localparam int PTR_W = $clog2(STK_DEPTH + 1);

    typedef struct packed {
        logic [STK_DEPTH-1:0][LVL_W-1:0] mem;
        logic [PTR_W-1:0]                ptr;
    } stk_t;

    stk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push_i && (st_q.ptr < PTR_W'(STK_DEPTH))) begin
            st_d.mem[st_q.ptr] = push_lvl_i;
            st_d.ptr           = st_q.ptr + 1'b1;
        end else if (pop_i && (st_q.ptr != '0)) begin
            st_d.ptr = st_q.ptr - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign top_o   = (st_q.ptr != '0) ? st_q.mem[st_q.ptr - 1'b1] : '0;
    assign depth_o = st_q.ptr;
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import prio_intc_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_EXT-1:0]  ext_irq_ni,
    input  logic                fiq_ni,
    input  logic [NUM_INTL-1:0] int_irq_i,
    input  logic                bus_wr_i,
    input  logic                bus_rd_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic [DATA_W-1:0]   bus_wdata_i,
    output logic [DATA_W-1:0]   bus_rdata_o,
    output logic                irq_o,
    output logic                fiq_o
);
    localparam int PTR_W = $clog2(STK_DEPTH + 1);

    typedef struct packed {
        logic [NSRC-1:0][LVL_W-1:0] lvl;
        logic [NSRC-1:0]            pend;
        lvl_t                       cur;
        logic [1:0]                 fsync;
    } state_t;

    state_t st_d, st_q;

    logic [NSRC-1:0]  set_pulse;
    logic             win_valid;
    logic [SRC_W-1:0] win_idx;
    lvl_t             win_lvl;
    logic             ack, eos, pop;
    lvl_t             stk_top;
    logic [PTR_W-1:0] stk_depth;
    lvl_t             cur_lvl;

    genvar g;
    generate
        for (g = 0; g < NUM_EXT; g++) begin : g_ext
            prio_intc_edge #(.SYNC_STAGES(2), .ACT_LOW(1'b1)) u_edge (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .req_i  (ext_irq_ni[g]),
                .pulse_o(set_pulse[g])
            );
        end
        for (g = 0; g < NUM_INTL; g++) begin : g_int
            prio_intc_edge #(.SYNC_STAGES(0), .ACT_LOW(1'b0)) u_edge (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .req_i  (int_irq_i[g]),
                .pulse_o(set_pulse[NUM_EXT+g])
            );
        end
    endgenerate

    prio_intc_arb u_arb (
        .pend_i     (st_q.pend),
        .lvl_i      (st_q.lvl),
        .cur_i      (st_q.cur),
        .win_valid_o(win_valid),
        .win_idx_o  (win_idx),
        .win_lvl_o  (win_lvl)
    );

    assign ack = bus_rd_i && (bus_addr_i == A_VEC) && win_valid;
    assign eos = bus_wr_i && (bus_addr_i == A_EOS);
    assign pop = eos && !ack;

    prio_intc_stack u_stack (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .push_i    (ack),
        .push_lvl_i(st_q.cur),
        .pop_i     (pop),
        .top_o     (stk_top),
        .depth_o   (stk_depth)
    );

    always_comb begin
        logic [NSRC-1:0] clr;
        st_d     = st_q;
        clr      = '0;
        st_d.fsync = {st_q.fsync[0], ~fiq_ni};

        if (bus_wr_i) begin
            for (int w = 0; w < NUM_LVL_WORDS; w++) begin
                for (int j = 0; j < LVL_PER_WORD; j++) begin
                    if ((bus_addr_i == ADDR_W'(w)) && (w * LVL_PER_WORD + j < NSRC))
                        st_d.lvl[w*LVL_PER_WORD+j] = bus_wdata_i[4*j +: LVL_W];
                end
            end
        end

        if (ack) begin
            clr[win_idx] = 1'b1;
            st_d.cur     = win_lvl;
        end else if (pop) begin
            st_d.cur = stk_top;
        end

        st_d.pend = (st_q.pend & ~clr) | set_pulse;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        bus_rdata_o = '0;
        if (bus_rd_i) begin
            if (bus_addr_i < ADDR_W'(NUM_LVL_WORDS)) begin
                for (int w = 0; w < NUM_LVL_WORDS; w++) begin
                    for (int j = 0; j < LVL_PER_WORD; j++) begin
                        if ((bus_addr_i == ADDR_W'(w)) && (w * LVL_PER_WORD + j < NSRC))
                            bus_rdata_o[4*j +: LVL_W] = st_q.lvl[w*LVL_PER_WORD+j];
                    end
                end
            end else if (bus_addr_i == A_PEND) begin
                bus_rdata_o[NSRC-1:0] = st_q.pend;
            end else if (bus_addr_i == A_VEC) begin
                if (win_valid) bus_rdata_o[SRC_W-1:0] = win_idx + 1'b1;
            end else if (bus_addr_i == A_CUR) begin
                bus_rdata_o[LVL_W-1:0] = st_q.cur;
            end
        end
    end

    assign cur_lvl = st_q.cur;
    assign irq_o   = win_valid;
    assign fiq_o   = st_q.fsync[1];
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk
    import prio_intc_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              fiq_ni,
    input logic              bus_wr_i,
    input logic              bus_rd_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [DATA_W-1:0] bus_rdata_o,
    input logic              irq_o,
    input logic              fiq_o,
    input lvl_t              cur_lvl,
    input logic [$clog2(STK_DEPTH+1)-1:0] stk_depth
);
    logic vec_ack;
    assign vec_ack = bus_rd_i && (bus_addr_i == A_VEC) && (bus_rdata_o != '0);

    AST_TOP_LEVEL_MASKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cur_lvl == '1) |-> !irq_o); // R4
    AST_IDLE_VECTOR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rd_i && (bus_addr_i == A_VEC) && !irq_o) |-> (bus_rdata_o == '0)); // R5
    AST_ACK_RAISES_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vec_ack |=> (cur_lvl > $past(cur_lvl))); // R7
    AST_ACK_GROWS_STACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vec_ack |=> (stk_depth == $past(stk_depth) + 1'b1)); // R7
    AST_EOS_LOWERS_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && (bus_addr_i == A_EOS) && !bus_rd_i && (stk_depth != '0))
        |=> (cur_lvl < $past(cur_lvl))); // R8
    AST_FIQ_FROM_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(fiq_o) |-> !$past(fiq_ni, 2)); // R9
endmodule

bind prio_intc prio_intc_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fiq_ni     (fiq_ni),
    .bus_wr_i   (bus_wr_i),
    .bus_rd_i   (bus_rd_i),
    .bus_addr_i (bus_addr_i),
    .bus_rdata_o(bus_rdata_o),
    .irq_o      (irq_o),
    .fiq_o      (fiq_o),
    .cur_lvl    (cur_lvl),
    .stk_depth  (stk_depth)
);

// File: tb/prio_intc_tb.sv
module prio_intc_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ext_n = 8'hFF;
    logic        fiq_n = 1'b1;
    logic [18:0] intr = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fiq;

    int checks = 0, failures = 0;
    bit done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    prio_intc u_dut (
        .clk_i(clk), .rst_ni(rst_n), .ext_irq_ni(ext_n), .fiq_ni(fiq_n),
        .int_irq_i(intr), .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
    );

    // Monitor: compares each read against the expected item queued by the driver
    always @(negedge clk) begin
        if (rd && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rdata !== e) begin
                failures++;
                $display("FAIL %s: read actual=%h expected=%h", t, rdata, e);
            end
        end
    end

    task automatic bus_read(input logic [2:0] a, input logic [31:0] e, input string t);
        @(posedge clk); #1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        rd = 1'b1; addr = a;
        @(posedge clk); #1;
        rd = 1'b0;
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        wr = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr = 1'b0;
    endtask

    task automatic chk_pin(input logic act, input logic e, input string t);
        @(negedge clk);
        checks++;
        if (act !== e) begin
            failures++;
            $display("FAIL %s: actual=%b expected=%b", t, act, e);
        end
    endtask

    task automatic ext_pulse(input int i);
        @(posedge clk); #1; ext_n[i] = 1'b0;
        repeat (2) @(posedge clk);
        #1; ext_n[i] = 1'b1;
        repeat (4) @(posedge clk);
    endtask

    task automatic int_pulse(input int k);
        @(posedge clk); #1; intr[k] = 1'b1;
        @(posedge clk); #1; intr[k] = 1'b0;
        repeat (2) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk_pin(irq, 1'b0, "R1 irq");
        chk_pin(fiq, 1'b0, "R1 fiq");
        bus_read(3'd5, 32'h0, "R1 vector");
        bus_read(3'd7, 32'h0, "R1 current");
        bus_read(3'd4, 32'h0, "R1 pending");
        bus_read(3'd0, 32'h0, "R1 levels");
        // R11 level map
        bus_write(3'd0, 32'h0000_0553);
        bus_write(3'd1, 32'h0000_0060);
        bus_write(3'd3, 32'h0000_0700);
        bus_read(3'd0, 32'h0000_0553, "R11 word0");
        bus_read(3'd3, 32'h0000_0700, "R11 word3");
        // R3, R10 internal source at level 0
        int_pulse(0);
        bus_read(3'd4, 32'h0000_0100, "R10 pending");
        chk_pin(irq, 1'b0, "R3 irq");
        // R2 two-cycle external pulse
        ext_pulse(0);
        bus_read(3'd4, 32'h0000_0101, "R2 pending");
        chk_pin(irq, 1'b1, "R4 irq level3");
        // R6 tie between sources 1 and 2 at level 5
        @(posedge clk); #1; ext_n[1] = 1'b0; ext_n[2] = 1'b0;
        repeat (2) @(posedge clk);
        #1; ext_n[1] = 1'b1; ext_n[2] = 1'b1;
        repeat (4) @(posedge clk);
        bus_read(3'd4, 32'h0000_0107, "R2 pending tie");
        bus_read(3'd5, 32'd2, "R6 vector tie");
        bus_read(3'd7, 32'd5, "R7 current");
        bus_read(3'd4, 32'h0000_0105, "R7 pending clear");
        chk_pin(irq, 1'b0, "R4 irq masked at equal level");
        // nested higher source
        int_pulse(1);
        chk_pin(irq, 1'b1, "R4 irq higher");
        bus_read(3'd5, 32'd10, "R5 vector level6");
        bus_read(3'd7, 32'd6, "R7 nested current");
        // R9 fast path during service
        @(posedge clk); #1; fiq_n = 1'b0;
        repeat (3) @(posedge clk);
        chk_pin(fiq, 1'b1, "R9 fiq asserted");
        #1; fiq_n = 1'b1;
        repeat (3) @(posedge clk);
        chk_pin(fiq, 1'b0, "R9 fiq released");
        // R8 unwinding
        bus_write(3'd6, 32'h0);
        bus_read(3'd7, 32'd5, "R8 pop to 5");
        chk_pin(irq, 1'b0, "R4 irq still masked");
        bus_write(3'd6, 32'h0);
        bus_read(3'd7, 32'd0, "R8 pop to 0");
        chk_pin(irq, 1'b1, "R4 irq after unwind");
        bus_read(3'd5, 32'd3, "R5 vector src2");
        bus_write(3'd6, 32'h0);
        bus_read(3'd5, 32'd1, "R5 vector src0");
        bus_read(3'd7, 32'd3, "R7 current 3");
        bus_write(3'd6, 32'h0);
        bus_read(3'd5, 32'd0, "R3 vector disabled only");
        bus_read(3'd4, 32'h0000_0100, "R3 pending kept");
        // top level source
        int_pulse(18);
        bus_read(3'd5, 32'd27, "R5 vector src26");
        bus_read(3'd7, 32'd7, "R7 current 7");
        bus_write(3'd6, 32'h0);
        bus_write(3'd6, 32'h0);
        bus_read(3'd7, 32'd0, "R8 empty pop");
        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule